// File: doc/BRIEF.md
# Load-Linked Reservation Tracker

This block sits in each node's cache controller and supports load-linked / store-conditional under a write-invalidate directory protocol. It holds one reservation. That reservation is a live flag plus the cache-line tag of the last load-linked. The block watches three things: local load-linked and store-conditional requests, incoming invalidations, and context-switch pulses. The state of the addressed line in the local cache arrives as an input alongside each request.

For every request it gives a registered verdict one cycle later. A load-linked either hits or calls for a shared copy of the line. A store-conditional either fails on the spot, succeeds on the spot, or goes to the line's home node. The home-side rule is a separate port group. A forwarded store-conditional is granted only while the directory shows the line shared, and the grant carries the mask of the other sharers to invalidate.

Top module: `llsc_resv_tracker`

## Requirements
- R1: After reset all outputs are low, and no reservation is held. A store-conditional on an exclusive line therefore fails locally.
- R2: A load-linked (`req_op`=0) on a line in state shared (1) or exclusive (2) sets the reservation. It answers code 1 (hit) with `fill_valid` low. Every response appears exactly one cycle after its request.
- R3: A load-linked on a line in state invalid (0) answers code 2. It pulses `fill_valid` with `fill_addr` equal to the request address with the line-offset bits cleared.
- R4: A store-conditional (`req_op`=1) without a live reservation answers code 5 (local fail) and raises no `fwd_valid`.
- R5: A store-conditional with a live reservation on an exclusive line answers code 4 (local success) and raises no `fwd_valid`.
- R6: A store-conditional with a live reservation on a shared or invalid line answers code 6. It pulses `fwd_valid` with `fwd_addr` equal to the full request address.
- R7: Any store-conditional, whatever its outcome, ends the reservation.
- R8: An invalidation whose address falls in the reserved line, at any offset, ends the reservation. An invalidation of any other line leaves it intact.
- R9: A context-switch pulse ends the reservation.
- R10: A new load-linked replaces the previous reservation. After that, invalidating the old line has no effect, and invalidating the new line does.
- R11: A matching invalidation or a context switch in the same cycle as a store-conditional makes it fail locally. Either one in the same cycle as a load-linked on that line leaves no reservation.
- R12: A home request (`home_dir`: 0 uncached, 1 shared, 2 exclusive, 3 reserved) answers one cycle later on `home_done`. It grants only for state 1, and then `home_inv_mask` is `home_sharers` with the requester's bit cleared. Otherwise `home_grant` and the mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request strobe |
| req_op | input | 1 | 0 load-linked, 1 store-conditional |
| req_addr | input | ADDR_W | Request byte address |
| req_line_state | input | 2 | Local line state: 0 invalid, 1 shared, 2 exclusive |
| inv_valid | input | 1 | Incoming invalidation strobe |
| inv_addr | input | ADDR_W | Invalidated address |
| ctx_switch | input | 1 | Context-switch pulse |
| resp_valid | output | 1 | Verdict strobe |
| resp_code | output | 3 | 1 hit, 2 fill, 4 SC ok, 5 SC fail, 6 SC to home |
| fill_valid | output | 1 | Request a shared copy |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| fwd_valid | output | 1 | Send store-conditional to home |
| fwd_addr | output | ADDR_W | Forwarded address |
| home_valid | input | 1 | Home-side store-conditional check strobe |
| home_dir | input | 2 | Directory state of the line |
| home_sharers | input | NODES | Sharer vector from the directory |
| home_src | input | NODE_W | Requesting node index |
| home_done | output | 1 | Home verdict strobe |
| home_grant | output | 1 | Store-conditional granted |
| home_inv_mask | output | NODES | Sharers to invalidate |

## Verification
The bench builds the tracker with 32-bit addresses, 32-byte lines and eight nodes. With 32-byte lines, two invalidation addresses separated by exactly one line land on either side of the tag boundary. One of them must kill the reservation and the other must leave it. Eight nodes leave room for a sharer pattern in which the requester is a sharer and for one in which it is not, so both forms of the mask rule are checked.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [0:0] {
      OP_LL = 1'b0,
      OP_SC = 1'b1
   } op_e;

   typedef enum logic [1:0] {
      LS_INVALID = 2'd0,
      LS_SHARED  = 2'd1,
      LS_EXCL    = 2'd2,
      LS_RSVD    = 2'd3
   } line_state_e;

   typedef enum logic [1:0] {
      DIR_UNCACHED = 2'd0,
      DIR_SHARED   = 2'd1,
      DIR_EXCL     = 2'd2,
      DIR_RSVD     = 2'd3
   } dir_state_e;

   typedef enum logic [2:0] {
      RC_NONE    = 3'd0,
      RC_LL_HIT  = 3'd1,
      RC_LL_FILL = 3'd2,
      RC_SC_OK   = 3'd4,
      RC_SC_FAIL = 3'd5,
      RC_SC_HOME = 3'd6
   } resp_code_e;

endpackage

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
   parameter int TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ll_set,
   input  logic             sc_seen,
   input  logic [TAG_W-1:0] ll_tag,
   input  logic             inv_valid,
   input  logic [TAG_W-1:0] inv_tag,
   input  logic             ctx_switch,
   output logic             live
);

   logic             held_q;
   logic [TAG_W-1:0] tag_q;
   logic             kill_old;
   logic             kill_new;
   logic             held_d;
   logic [TAG_W-1:0] tag_d;

   // a reservation is alive this cycle only if nothing kills it in the same cycle
   assign kill_old = ctx_switch | (inv_valid & (inv_tag == tag_q));
   assign kill_new = ctx_switch | (inv_valid & (inv_tag == ll_tag));
   assign live     = held_q & ~kill_old;

   always_comb begin
      held_d = held_q & ~kill_old;
      tag_d  = tag_q;
      if (ll_set) begin
         held_d = ~kill_new;
         tag_d  = ll_tag;
      end else if (sc_seen) begin
         held_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         held_q <= held_d;
         tag_q  <= tag_d;
      end
   end

endmodule

// File: rtl/llsc_sc_resolver.sv
module llsc_sc_resolver
   import llsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 5
) (
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        line_state,
   input  logic              resv_live,
   output resp_code_e        code,
   output logic              need_fill,
   output logic              need_fwd,
   output logic [ADDR_W-1:0] line_base
);

   line_state_e ls;
   assign ls = line_state_e'(line_state);

   generate
      if (OFFS_W == 0) begin : g_byte_lines
         assign line_base = req_addr;
      end else begin : g_wide_lines
         assign line_base = {req_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      code      = RC_NONE;
      need_fill = 1'b0;
      need_fwd  = 1'b0;
      if (req_valid) begin
         if (op_e'(req_op) == OP_LL) begin
            if (ls == LS_SHARED || ls == LS_EXCL) begin
               code = RC_LL_HIT;
            end else begin
               code      = RC_LL_FILL;
               need_fill = 1'b1;
            end
         end else if (!resv_live) begin
            code = RC_SC_FAIL;
         end else if (ls == LS_EXCL) begin
            code = RC_SC_OK;
         end else begin
            code     = RC_SC_HOME;
            need_fwd = 1'b1;
         end
      end
   end

endmodule

// File: rtl/llsc_home_judge.sv
module llsc_home_judge
   import llsc_pkg::*;
#(
   parameter int NODES  = 8,
   parameter int NODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              home_valid,
   input  logic [1:0]        home_dir,
   input  logic [NODES-1:0]  home_sharers,
   input  logic [NODE_W-1:0] home_src,
   output logic              home_done,
   output logic              home_grant,
   output logic [NODES-1:0]  home_inv_mask
);

   logic             grant_c;
   logic [NODES-1:0] others_c;

   assign grant_c = home_valid & (dir_state_e'(home_dir) == DIR_SHARED);

   for (genvar n = 0; n < NODES; n++) begin : g_node
      assign others_c[n] = home_sharers[n] & (home_src != NODE_W'(n));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         home_done     <= 1'b0;
         home_grant    <= 1'b0;
         home_inv_mask <= '0;
      end else begin
         home_done     <= home_valid;
         home_grant    <= grant_c;
         home_inv_mask <= grant_c ? others_c : '0;
      end
   end

endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker
   import llsc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int NODES      = 8,
   parameter int NODE_W     = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_line_state,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic              ctx_switch,
   output logic              resp_valid,
   output logic [2:0]        resp_code,
   output logic              fill_valid,
   output logic [ADDR_W-1:0] fill_addr,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   input  logic              home_valid,
   input  logic [1:0]        home_dir,
   input  logic [NODES-1:0]  home_sharers,
   input  logic [NODE_W-1:0] home_src,
   output logic              home_done,
   output logic              home_grant,
   output logic [NODES-1:0]  home_inv_mask
);

   localparam int OFFS_W = $clog2(LINE_BYTES);
   localparam int TAG_W  = ADDR_W - OFFS_W;

   generate
      if ((1 << OFFS_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed the line offset width");
      end
      if (NODES < 2 || (1 << NODE_W) < NODES) begin : g_bad_nodes
         $error("NODES must be at least 2 and fit in NODE_W bits");
      end
   endgenerate

   logic [TAG_W-1:0]  req_tag;
   logic [TAG_W-1:0]  inv_tag;
   logic              resv_live;
   logic              ll_set;
   logic              sc_seen;
   resp_code_e        code_c;
   logic              fill_c;
   logic              fwd_c;
   logic [ADDR_W-1:0] base_c;

   assign req_tag = req_addr[ADDR_W-1:OFFS_W];
   assign inv_tag = inv_addr[ADDR_W-1:OFFS_W];
   assign ll_set  = req_valid & (op_e'(req_op) == OP_LL);
   assign sc_seen = req_valid & (op_e'(req_op) == OP_SC);

   llsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .ll_set     (ll_set),
      .sc_seen    (sc_seen),
      .ll_tag     (req_tag),
      .inv_valid  (inv_valid),
      .inv_tag    (inv_tag),
      .ctx_switch (ctx_switch),
      .live       (resv_live)
   );

   llsc_sc_resolver #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_resolve (
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .line_state (req_line_state),
      .resv_live  (resv_live),
      .code       (code_c),
      .need_fill  (fill_c),
      .need_fwd   (fwd_c),
      .line_base  (base_c)
   );

   llsc_home_judge #(.NODES(NODES), .NODE_W(NODE_W)) u_home (
      .clk           (clk),
      .rst_n         (rst_n),
      .home_valid    (home_valid),
      .home_dir      (home_dir),
      .home_sharers  (home_sharers),
      .home_src      (home_src),
      .home_done     (home_done),
      .home_grant    (home_grant),
      .home_inv_mask (home_inv_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_code  <= RC_NONE;
         fill_valid <= 1'b0;
         fill_addr  <= '0;
         fwd_valid  <= 1'b0;
         fwd_addr   <= '0;
      end else begin
         resp_valid <= req_valid;
         resp_code  <= code_c;
         fill_valid <= fill_c;
         fill_addr  <= fill_c ? base_c : '0;
         fwd_valid  <= fwd_c;
         fwd_addr   <= fwd_c ? req_addr : '0;
      end
   end

endmodule

// File: rtl/llsc_resv_tracker_sva.sv
module llsc_resv_tracker_sva #(
   parameter int ADDR_W = 32,
   parameter int NODES  = 8,
   parameter int NODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_op,
   input logic [1:0]        req_line_state,
   input logic              ctx_switch,
   input logic              resp_valid,
   input logic [2:0]        resp_code,
   input logic              fill_valid,
   input logic              fwd_valid,
   input logic              home_valid,
   input logic [1:0]        home_dir,
   input logic [NODE_W-1:0] home_src,
   input logic              home_done,
   input logic              home_grant,
   input logic [NODES-1:0]  home_inv_mask
);

   p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   p_miss_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op && req_line_state == 2'd0) |=> (fill_valid && resp_code == 3'd2));

   p_fail_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 3'd5) |-> !fwd_valid);

   p_ok_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 3'd4) |-> (!fwd_valid && !fill_valid));

   p_sc_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_valid && req_op) ##1 (req_valid && req_op)) |=> (resp_code == 3'd5));

   p_ctx_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_switch ##1 (req_valid && req_op)) |=> (resp_code == 3'd5));

   p_ctx_same_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_switch && req_valid && req_op) |=> (resp_code == 3'd5));

   p_home_deny_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (home_valid && home_dir != 2'd1) |=> (home_done && !home_grant && home_inv_mask == '0));

   p_home_self_r12: assert property (@(posedge clk) disable iff (!rst_n)
      home_valid |=> (home_inv_mask[$past(home_src)] == 1'b0));

endmodule

bind llsc_resv_tracker llsc_resv_tracker_sva #(
   .ADDR_W (ADDR_W),
   .NODES  (NODES),
   .NODE_W (NODE_W)
) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_op         (req_op),
   .req_line_state (req_line_state),
   .ctx_switch     (ctx_switch),
   .resp_valid     (resp_valid),
   .resp_code      (resp_code),
   .fill_valid     (fill_valid),
   .fwd_valid      (fwd_valid),
   .home_valid     (home_valid),
   .home_dir       (home_dir),
   .home_src       (home_src),
   .home_done      (home_done),
   .home_grant     (home_grant),
   .home_inv_mask  (home_inv_mask)
);

// File: tb/llsc_resv_tracker_tb.sv
`timescale 1ns/100ps
module llsc_resv_tracker_tb;

   localparam int AW = 32;
   localparam int NN = 8;
   localparam int NW = 3;
   localparam logic [2:0] C_HIT = 3'd1, C_FILL = 3'd2, C_OK = 3'd4, C_FAIL = 3'd5, C_HOME = 3'd6;
   localparam logic [1:0] S_INV = 2'd0, S_SH = 2'd1, S_EX = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_op = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_line_state = '0;
   logic          inv_valid = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic          ctx_switch = 1'b0;
   logic          resp_valid, fill_valid, fwd_valid;
   logic [2:0]    resp_code;
   logic [AW-1:0] fill_addr, fwd_addr;
   logic          home_valid = 1'b0;
   logic [1:0]    home_dir = '0;
   logic [NN-1:0] home_sharers = '0;
   logic [NW-1:0] home_src = '0;
   logic          home_done, home_grant;
   logic [NN-1:0] home_inv_mask;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   llsc_resv_tracker #(.ADDR_W(AW), .LINE_BYTES(32), .NODES(NN)) u_dut (.*);

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one request cycle (optionally with invalidation / context switch)
   task automatic issue(logic op, logic [AW-1:0] a, logic [1:0] ls,
                        logic iv, logic [AW-1:0] ia, logic cx);
      req_valid = 1'b1; req_op = op; req_addr = a; req_line_state = ls;
      inv_valid = iv; inv_addr = ia; ctx_switch = cx;
      @(negedge clk);
      req_valid = 1'b0; inv_valid = 1'b0; ctx_switch = 1'b0;
   endtask

   task automatic side(logic iv, logic [AW-1:0] ia, logic cx);
      inv_valid = iv; inv_addr = ia; ctx_switch = cx;
      @(negedge clk);
      inv_valid = 1'b0; ctx_switch = 1'b0;
   endtask

   task automatic sc_expect(string req, logic [1:0] ls, logic [2:0] exp);
      issue(1'b1, 32'h0000_0100, ls, 1'b0, '0, 1'b0);
      check(req, resp_code, exp);
   endtask

   task automatic t_reset();
      check("R1 resp_valid", resp_valid, 0);
      check("R1 fill_valid", fill_valid, 0);
      check("R1 fwd_valid", fwd_valid, 0);
      check("R1 home_done", home_done, 0);
      sc_expect("R1 no reservation", S_EX, C_FAIL);
      check("R4 no forward on fail", fwd_valid, 0);
   endtask

   task automatic t_ll_hit();
      issue(1'b0, 32'h0000_1000, S_SH, 1'b0, '0, 1'b0);
      check("R2 resp_valid", resp_valid, 1);
      check("R2 hit code", resp_code, C_HIT);
      check("R2 no fill", fill_valid, 0);
      @(negedge clk);
      check("R2 single pulse", resp_valid, 0);
      sc_expect("R5 local ok", S_EX, C_OK);
      check("R5 no forward", fwd_valid, 0);
   endtask

   task automatic t_ll_miss();
      issue(1'b0, 32'h0000_2014, S_INV, 1'b0, '0, 1'b0);
      check("R3 fill code", resp_code, C_FILL);
      check("R3 fill_valid", fill_valid, 1);
      check("R3 fill_addr", fill_addr, 32'h0000_2000);
      issue(1'b1, 32'h0000_2014, S_SH, 1'b0, '0, 1'b0);
      check("R6 home code", resp_code, C_HOME);
      check("R6 fwd_valid", fwd_valid, 1);
      check("R6 fwd_addr", fwd_addr, 32'h0000_2014);
      sc_expect("R7 cleared after SC", S_EX, C_FAIL);
      issue(1'b0, 32'h0000_2040, S_EX, 1'b0, '0, 1'b0);
      sc_expect("R6 invalid line goes home", S_INV, C_HOME);
      issue(1'b0, 32'h0000_2040, S_EX, 1'b0, '0, 1'b0);
      sc_expect("R7 ok SC", S_EX, C_OK);
      sc_expect("R7 cleared after ok", S_EX, C_FAIL);
   endtask

   task automatic t_inval();
      issue(1'b0, 32'h0000_3000, S_SH, 1'b0, '0, 1'b0);
      side(1'b1, 32'h0000_301C, 1'b0);
      sc_expect("R8 same line kills", S_EX, C_FAIL);
      issue(1'b0, 32'h0000_3000, S_SH, 1'b0, '0, 1'b0);
      side(1'b1, 32'h0000_3020, 1'b0);
      sc_expect("R8 next line ignored", S_EX, C_OK);
   endtask

   task automatic t_ctx();
      issue(1'b0, 32'h0000_3800, S_SH, 1'b0, '0, 1'b0);
      side(1'b0, '0, 1'b1);
      sc_expect("R9 context switch kills", S_EX, C_FAIL);
   endtask

   task automatic t_replace();
      issue(1'b0, 32'h0000_4000, S_SH, 1'b0, '0, 1'b0);
      issue(1'b0, 32'h0000_5000, S_SH, 1'b0, '0, 1'b0);
      side(1'b1, 32'h0000_4000, 1'b0);
      sc_expect("R10 old line ignored", S_EX, C_OK);
      issue(1'b0, 32'h0000_4000, S_SH, 1'b0, '0, 1'b0);
      issue(1'b0, 32'h0000_5000, S_SH, 1'b0, '0, 1'b0);
      side(1'b1, 32'h0000_5008, 1'b0);
      sc_expect("R10 new line kills", S_EX, C_FAIL);
   endtask

   task automatic t_same_cycle();
      issue(1'b0, 32'h0000_6000, S_SH, 1'b0, '0, 1'b0);
      issue(1'b1, 32'h0000_6000, S_EX, 1'b1, 32'h0000_6004, 1'b0);
      check("R11 inv with SC fails", resp_code, C_FAIL);
      issue(1'b0, 32'h0000_6000, S_SH, 1'b0, '0, 1'b0);
      issue(1'b1, 32'h0000_6000, S_EX, 1'b0, '0, 1'b1);
      check("R11 ctx with SC fails", resp_code, C_FAIL);
      issue(1'b0, 32'h0000_6000, S_SH, 1'b0, '0, 1'b1);
      sc_expect("R11 ctx with LL", S_EX, C_FAIL);
      issue(1'b0, 32'h0000_6000, S_SH, 1'b1, 32'h0000_601F, 1'b0);
      sc_expect("R11 inv with LL", S_EX, C_FAIL);
      issue(1'b0, 32'h0000_6000, S_SH, 1'b1, 32'h0000_7000, 1'b0);
      sc_expect("R11 other-line inv with LL", S_EX, C_OK);
   endtask

   task automatic home(logic [1:0] d, logic [NN-1:0] sh, logic [NW-1:0] src,
                       logic g, logic [NN-1:0] m, string req);
      home_valid = 1'b1; home_dir = d; home_sharers = sh; home_src = src;
      @(negedge clk);
      home_valid = 1'b0;
      check({req, " done"}, home_done, 1);
      check({req, " grant"}, home_grant, g);
      check({req, " mask"}, home_inv_mask, m);
   endtask

   task automatic t_home();
      home(2'd0, 8'hB5, 3'd2, 1'b0, 8'h00, "R12 uncached");
      home(2'd2, 8'hB5, 3'd2, 1'b0, 8'h00, "R12 exclusive");
      home(2'd1, 8'hB5, 3'd2, 1'b1, 8'hB1, "R12 shared self");
      home(2'd1, 8'hB5, 3'd3, 1'b1, 8'hB5, "R12 shared non-sharer");
      @(negedge clk);
      check("R12 done pulse", home_done, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ll_hit();
      t_ll_miss();
      t_inval();
      t_ctx();
      t_replace();
      t_same_cycle();
      t_home();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule